// File: doc/BRIEF.md
# Reduced Integer Instruction Decoder

This block turns one 32-bit instruction word into the control bundle that a small five-stage integer pipeline uses in its decode stage. It extracts the two register read addresses, picks the destination register and decides whether it is written, selects the ALU operation, and chooses between a sign- and zero-extended immediate. It also tells the datapath whether operand B comes from the register file or from the immediate, and flags unconditional jumps and jump-and-link.

A small subset of the register, immediate and jump formats is supported. Every other encoding is still classified, but it is steered into an inert bundle: no register write, no jump, the add code on the ALU, and register operands only. An unknown word therefore behaves as a no-op and cannot corrupt the register file. The decoded bundle is registered, so it fits directly between the fetch and execute stages.

Top module: `rdec_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every output is cleared to zero on that edge; in particular `wr_en_o`, `jump_o` and `link_o` are 0.
- R2: With the default `OUT_REG=1`, the outputs after a rising edge describe the word on `instr_i` at that edge. `rs_addr_o` is bits [25:21] and `rt_addr_o` is bits [20:16], for every word including unsupported ones.
- R3: Opcode 000000 with funct (bits [5:0]) 100001, 100011, 100100, 100101, 100110 or 100111 selects add, subtract, and, or, xor or nor. The ALU codes are 0, 1, 2, 3, 4 and 5 on `alu_op_o`. These words write register bits [15:11], with `opb_imm_o`=0 and `imm_sign_o`=0.
- R4: Opcodes 001001 (add immediate, sign-extended, ALU code 0), 001100 (and, code 2), 001101 (or, code 3) and 001110 (xor, code 4) write register bits [20:16], with `opb_imm_o`=1. `imm_sign_o` is 1 only for 001001.
- R5: Opcode 000010 gives `jump_o`=1, `link_o`=0 and `wr_en_o`=0, with `wr_addr_o`=0.
- R6: Opcode 000011 gives `jump_o`=1, `link_o`=1 and `wr_en_o`=1, with `wr_addr_o`=31.
- R7: When the selected destination is register 0, `wr_en_o` is 0.
- R8: Any other opcode, or opcode 000000 with any other funct, gives `wr_en_o`=0, `wr_addr_o`=0, `jump_o`=0, `link_o`=0, `alu_op_o`=0, `opb_imm_o`=0 and `imm_sign_o`=0. This includes the 0100xx group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word to decode |
| rs_addr_o | output | 5 | First register read address |
| rt_addr_o | output | 5 | Second register read address |
| wr_addr_o | output | 5 | Destination register address |
| wr_en_o | output | 1 | Register-file write enable |
| alu_op_o | output | 4 | ALU operation code |
| imm_sign_o | output | 1 | 1: sign-extend immediate, 0: zero-extend |
| opb_imm_o | output | 1 | 1: operand B is the extended immediate |
| jump_o | output | 1 | Unconditional jump |
| link_o | output | 1 | Jump also writes the return address |

## Verification
Every decoded output is due exactly one rising edge after the word is placed on `instr_i`, because one output register sits between input and ports. The bench therefore drives each word on a falling edge and samples on the next falling edge, half a period after the register has updated. Reset clearing is likewise checked on the falling edge that follows the reset edge, with a writing instruction still applied, so that a missed clear shows up.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

  localparam int OPC_W   = 6;
  localparam int FUNCT_W = 6;
  localparam int ALU_W   = 4;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 4'd0,
    ALU_SUB = 4'd1,
    ALU_AND = 4'd2,
    ALU_OR  = 4'd3,
    ALU_XOR = 4'd4,
    ALU_NOR = 4'd5
  } alu_op_e;

  typedef enum logic [2:0] {
    CL_NONE  = 3'd0,
    CL_REG   = 3'd1,
    CL_IMM   = 3'd2,
    CL_JUMP  = 3'd3,
    CL_LINK  = 3'd4
  } ins_class_e;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_JMP     = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_JAL     = 6'b000011;
  localparam logic [OPC_W-1:0] OPC_ADDI    = 6'b001001;
  localparam logic [OPC_W-1:0] OPC_ANDI    = 6'b001100;
  localparam logic [OPC_W-1:0] OPC_ORI     = 6'b001101;
  localparam logic [OPC_W-1:0] OPC_XORI    = 6'b001110;

  localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100001;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100011;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FUNCT_W-1:0] FN_XOR = 6'b100110;
  localparam logic [FUNCT_W-1:0] FN_NOR = 6'b100111;

  typedef struct packed {
    ins_class_e cls;
    alu_op_e    alu;
    logic       sx;
    logic       bimm;
  } op_ctrl_t;

endpackage

// File: rtl/rdec_opdecode.sv
module rdec_opdecode
  import rdec_pkg::*;
(
  input  logic [OPC_W-1:0]   opc_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output op_ctrl_t           ctrl_o
);

  op_ctrl_t reg_ctrl;

  // Register-format operation select from the function field
  always_comb begin
    reg_ctrl = '{cls: CL_REG, alu: ALU_ADD, sx: 1'b0, bimm: 1'b0};
    case (funct_i)
      FN_ADD:  reg_ctrl.alu = ALU_ADD;
      FN_SUB:  reg_ctrl.alu = ALU_SUB;
      FN_AND:  reg_ctrl.alu = ALU_AND;
      FN_OR:   reg_ctrl.alu = ALU_OR;
      FN_XOR:  reg_ctrl.alu = ALU_XOR;
      FN_NOR:  reg_ctrl.alu = ALU_NOR;
      default: reg_ctrl.cls = CL_NONE;
    endcase
  end

  // Major opcode classification; unknown words fall to the inert bundle
  always_comb begin
    ctrl_o = '{cls: CL_NONE, alu: ALU_ADD, sx: 1'b0, bimm: 1'b0};
    case (opc_i)
      OPC_SPECIAL: begin
        if (reg_ctrl.cls == CL_REG) ctrl_o = reg_ctrl;
      end
      OPC_JMP:  ctrl_o.cls = CL_JUMP;
      OPC_JAL:  ctrl_o.cls = CL_LINK;
      OPC_ADDI: ctrl_o = '{cls: CL_IMM, alu: ALU_ADD, sx: 1'b1, bimm: 1'b1};
      OPC_ANDI: ctrl_o = '{cls: CL_IMM, alu: ALU_AND, sx: 1'b0, bimm: 1'b1};
      OPC_ORI:  ctrl_o = '{cls: CL_IMM, alu: ALU_OR,  sx: 1'b0, bimm: 1'b1};
      OPC_XORI: ctrl_o = '{cls: CL_IMM, alu: ALU_XOR, sx: 1'b0, bimm: 1'b1};
      default:  ctrl_o.cls = CL_NONE;
    endcase
  end

  // R8: the inert bundle never carries an immediate or a non-add code
  always_comb begin
    if (ctrl_o.cls == CL_NONE) begin
      p_inert_bundle_r8: assert (ctrl_o.alu == ALU_ADD && !ctrl_o.bimm && !ctrl_o.sx)
        else $error("inert class with live controls");
    end
  end

endmodule

// File: rtl/rdec_wsel.sv
module rdec_wsel
  import rdec_pkg::*;
#(
  parameter int AW       = 5,
  parameter int LINK_REG = 31
) (
  input  ins_class_e      cls_i,
  input  logic [AW-1:0]   rt_i,
  input  logic [AW-1:0]   rd_i,
  output logic [AW-1:0]   waddr_o,
  output logic            wen_o
);

  localparam logic [AW-1:0] LINK_A = AW'(LINK_REG);
  localparam logic [AW-1:0] ZERO_A = '0;

  logic [AW-1:0] dest;
  logic          wants;

  always_comb begin
    dest  = ZERO_A;
    wants = 1'b0;
    case (cls_i)
      CL_REG:  begin dest = rd_i;   wants = 1'b1; end
      CL_IMM:  begin dest = rt_i;   wants = 1'b1; end
      CL_LINK: begin dest = LINK_A; wants = 1'b1; end
      default: begin dest = ZERO_A; wants = 1'b0; end
    endcase
  end

  assign waddr_o = dest;
  assign wen_o   = wants && (dest != ZERO_A);

endmodule

// File: rtl/rdec_decoder.sv
module rdec_decoder
  import rdec_pkg::*;
#(
  parameter int IW       = 32,
  parameter int AW       = 5,
  parameter int LINK_REG = 31,
  parameter bit OUT_REG  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IW-1:0]     instr_i,
  output logic [AW-1:0]     rs_addr_o,
  output logic [AW-1:0]     rt_addr_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic              wr_en_o,
  output logic [ALU_W-1:0]  alu_op_o,
  output logic              imm_sign_o,
  output logic              opb_imm_o,
  output logic              jump_o,
  output logic              link_o
);

  localparam int OPC_LSB = IW - OPC_W;
  localparam int RS_LSB  = OPC_LSB - AW;
  localparam int RT_LSB  = RS_LSB - AW;
  localparam int RD_LSB  = RT_LSB - AW;

  logic [OPC_W-1:0]   opc;
  logic [FUNCT_W-1:0] funct;
  logic [AW-1:0]      f_rs, f_rt, f_rd;
  logic [RD_LSB-FUNCT_W-1:0] unused_shamt;

  assign opc          = instr_i[IW-1:OPC_LSB];
  assign f_rs         = instr_i[RS_LSB +: AW];
  assign f_rt         = instr_i[RT_LSB +: AW];
  assign f_rd         = instr_i[RD_LSB +: AW];
  assign funct        = instr_i[FUNCT_W-1:0];
  assign unused_shamt = instr_i[RD_LSB-1:FUNCT_W];

  op_ctrl_t      ctrl;
  logic [AW-1:0] n_waddr;
  logic          n_wen;

  rdec_opdecode u_opdec (
    .opc_i   (opc),
    .funct_i (funct),
    .ctrl_o  (ctrl)
  );

  rdec_wsel #(.AW(AW), .LINK_REG(LINK_REG)) u_wsel (
    .cls_i   (ctrl.cls),
    .rt_i    (f_rt),
    .rd_i    (f_rd),
    .waddr_o (n_waddr),
    .wen_o   (n_wen)
  );

  logic n_jump, n_link;
  assign n_jump = (ctrl.cls == CL_JUMP) || (ctrl.cls == CL_LINK);
  assign n_link = (ctrl.cls == CL_LINK);

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          rs_addr_o  <= '0;
          rt_addr_o  <= '0;
          wr_addr_o  <= '0;
          wr_en_o    <= 1'b0;
          alu_op_o   <= '0;
          imm_sign_o <= 1'b0;
          opb_imm_o  <= 1'b0;
          jump_o     <= 1'b0;
          link_o     <= 1'b0;
        end else begin
          rs_addr_o  <= f_rs;
          rt_addr_o  <= f_rt;
          wr_addr_o  <= n_waddr;
          wr_en_o    <= n_wen;
          alu_op_o   <= ctrl.alu;
          imm_sign_o <= ctrl.sx;
          opb_imm_o  <= ctrl.bimm;
          jump_o     <= n_jump;
          link_o     <= n_link;
        end
      end

      // R1: cleared state after a reset edge
      p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!wr_en_o && !jump_o && !link_o && alu_op_o == '0))
        else $error("outputs not cleared by reset");

      // R2: read addresses follow the previous word's fields
      p_field_pass_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rs_addr_o == $past(f_rs) && rt_addr_o == $past(f_rt)))
        else $error("read address mismatch");

      // R5: plain jump never writes
      p_jump_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(opc) == OPC_JMP) |-> (jump_o && !link_o && !wr_en_o))
        else $error("plain jump decode wrong");

      // R6: link writes the fixed return register
      p_link_dest_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(opc) == OPC_JAL) |->
          (jump_o && link_o && wr_en_o && wr_addr_o == AW'(LINK_REG)))
        else $error("link decode wrong");

      p_link_is_jump_r6: assert property (@(posedge clk) disable iff (rst)
        link_o |-> jump_o)
        else $error("link without jump");

      // R7: never a write to register 0
      p_zero_dest_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (wr_addr_o != '0))
        else $error("write enabled to register 0");

      // R8: the 0100xx group stays inert
      p_group_inert_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(opc[OPC_W-1:2]) == 4'b0100) |->
          (!wr_en_o && !jump_o && !opb_imm_o))
        else $error("reserved group not inert");

      // R4: an immediate operand never accompanies a jump
      p_imm_not_jump_r4: assert property (@(posedge clk) disable iff (rst)
        opb_imm_o |-> !jump_o)
        else $error("immediate with jump");
    end else begin : g_comb
      assign rs_addr_o  = f_rs;
      assign rt_addr_o  = f_rt;
      assign wr_addr_o  = n_waddr;
      assign wr_en_o    = n_wen;
      assign alu_op_o   = ctrl.alu;
      assign imm_sign_o = ctrl.sx;
      assign opb_imm_o  = ctrl.bimm;
      assign jump_o     = n_jump;
      assign link_o     = n_link;
    end
  endgenerate

endmodule

// File: tb/rdec_decoder_bench.sv
module rdec_decoder_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [4:0]  rs_a, rt_a, wr_a;
  logic        wr_en, imm_sign, opb_imm, jump, link;
  logic [3:0]  alu_op;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rdec_decoder u_rdec_decoder (
    .clk(clk), .rst(rst), .instr_i(instr),
    .rs_addr_o(rs_a), .rt_addr_o(rt_a), .wr_addr_o(wr_a), .wr_en_o(wr_en),
    .alu_op_o(alu_op), .imm_sign_o(imm_sign), .opb_imm_o(opb_imm),
    .jump_o(jump), .link_o(link)
  );

  // expected bundle: {we, wa, alu, sx, bimm, j, l}
  typedef struct packed {
    logic [31:0] ins;
    logic [3:0]  req;
    logic        we;
    logic [4:0]  wa;
    logic [3:0]  alu;
    logic        sx;
    logic        bimm;
    logic        j;
    logic        l;
  } vec_t;

  function automatic logic [31:0] rw(input logic [4:0] s, input logic [4:0] t,
                                     input logic [4:0] d, input logic [5:0] f);
    return {6'b000000, s, t, d, 5'd3, f};
  endfunction

  function automatic logic [31:0] iw(input logic [5:0] o, input logic [4:0] s,
                                     input logic [4:0] t, input logic [15:0] k);
    return {o, s, t, k};
  endfunction

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{rw(5'd1, 5'd2, 5'd3,  6'b100001), 4'd3, 1'b1, 5'd3,  4'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 add
    '{rw(5'd9, 5'd2, 5'd4,  6'b100011), 4'd3, 1'b1, 5'd4,  4'd1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 sub
    '{rw(5'd1, 5'd7, 5'd5,  6'b100100), 4'd3, 1'b1, 5'd5,  4'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 and
    '{rw(5'd1, 5'd2, 5'd6,  6'b100101), 4'd3, 1'b1, 5'd6,  4'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 or
    '{rw(5'd30,5'd2, 5'd7,  6'b100110), 4'd3, 1'b1, 5'd7,  4'd4, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 xor
    '{rw(5'd1, 5'd31,5'd31, 6'b100111), 4'd3, 1'b1, 5'd31, 4'd5, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 nor
    '{iw(6'b001001, 5'd1, 5'd8,  16'hFFFF), 4'd4, 1'b1, 5'd8,  4'd0, 1'b1, 1'b1, 1'b0, 1'b0}, // R4
    '{iw(6'b001100, 5'd2, 5'd9,  16'h8000), 4'd4, 1'b1, 5'd9,  4'd2, 1'b0, 1'b1, 1'b0, 1'b0}, // R4
    '{iw(6'b001101, 5'd3, 5'd10, 16'h00F0), 4'd4, 1'b1, 5'd10, 4'd3, 1'b0, 1'b1, 1'b0, 1'b0}, // R4
    '{iw(6'b001110, 5'd4, 5'd11, 16'h1234), 4'd4, 1'b1, 5'd11, 4'd4, 1'b0, 1'b1, 1'b0, 1'b0}, // R4
    '{{6'b000010, 26'h155_5555},            4'd5, 1'b0, 5'd0,  4'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R5
    '{{6'b000011, 26'h2AA_AAAA},            4'd6, 1'b1, 5'd31, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1}, // R6
    '{rw(5'd1, 5'd2, 5'd0,  6'b100001), 4'd7, 1'b0, 5'd0,  4'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7
    '{iw(6'b001001, 5'd5, 5'd0, 16'h0001), 4'd7, 1'b0, 5'd0, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0}, // R7
    '{rw(5'd1, 5'd2, 5'd5,  6'b000000), 4'd8, 1'b0, 5'd0,  4'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R8
    '{iw(6'b010001, 5'd6, 5'd7, 16'hABCD), 4'd8, 1'b0, 5'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R8
    '{iw(6'b100011, 5'd6, 5'd12,16'h0004), 4'd8, 1'b0, 5'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R8
    '{iw(6'b001010, 5'd6, 5'd13,16'h0004), 4'd8, 1'b0, 5'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0}  // R8
  };

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // drive on a falling edge; outputs due after the next rising edge
  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    instr = w;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state with a writing word present
    instr = rw(5'd1, 5'd2, 5'd3, 6'b100001);
    repeat (3) @(negedge clk);
    chk("R1", "wr_en", 32'(wr_en), 0);
    chk("R1", "jump", 32'(jump), 0);
    chk("R1", "rs", 32'(rs_a), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string tg;
      apply(VT[i].ins);
      tg = $sformatf("R%0d[%0d]", VT[i].req, i);
      chk("R2", "rs", 32'(rs_a), 32'(VT[i].ins[25:21]));
      chk("R2", "rt", 32'(rt_a), 32'(VT[i].ins[20:16]));
      chk(tg, "wr_en", 32'(wr_en), 32'(VT[i].we));
      chk(tg, "wr_addr", 32'(wr_a), 32'(VT[i].wa));
      chk(tg, "alu_op", 32'(alu_op), 32'(VT[i].alu));
      chk(tg, "imm_sign", 32'(imm_sign), 32'(VT[i].sx));
      chk(tg, "opb_imm", 32'(opb_imm), 32'(VT[i].bimm));
      chk(tg, "jump", 32'(jump), 32'(VT[i].j));
      chk(tg, "link", 32'(link), 32'(VT[i].l));
    end

    // R2: a word changed mid-cycle is not visible before the next edge
    apply(rw(5'd1, 5'd2, 5'd3, 6'b100011));
    instr = {6'b000010, 26'd0};
    #1;
    chk("R2", "hold alu_op", 32'(alu_op), 1);
    chk("R2", "hold jump", 32'(jump), 0);
    @(negedge clk);
    chk("R2", "next jump", 32'(jump), 1);

    // R8 after R6: unknown word right after link clears everything
    apply({6'b000011, 26'd0});
    apply(iw(6'b010011, 5'd1, 5'd1, 16'h0));
    chk("R8", "wr_en after link", 32'(wr_en), 0);
    chk("R8", "link after link", 32'(link), 0);

    // R1: reset mid-stream clears a live write
    apply(iw(6'b001101, 5'd1, 5'd20, 16'h1));
    chk("R4", "pre-reset wr_en", 32'(wr_en), 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "wr_en", 32'(wr_en), 0);
    chk("R1", "wr_addr", 32'(wr_a), 0);
    chk("R1", "opb_imm", 32'(opb_imm), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R4", "post-reset wr_addr", 32'(wr_a), 20);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule